// File: doc/BRIEF.md
# Paged-Address Byte-Wide SRAM Controller

This block gives a host a 32-bit word read/write path to an asynchronous SRAM or PSRAM while keeping the pin count low. It drives only the low part of the memory address on every access. The upper part sits in an external page latch, and the controller reloads that latch only when a request targets a page other than the one last loaded.

Data moves one byte at a time over an 8-bit bus, so every word costs four byte cycles. The byte at the lowest address carries the least significant byte. The host talks to the block through a valid/ready request carrying a byte address, a write flag and write data. Reads return a one-cycle valid strobe together with the assembled word. A request whose address is not a multiple of four is refused with an error pulse, and no memory cycle is issued for it.

Top module: `paged_sram_ctrl`

## Requirements
- R1: After reset `req_ready_o` is high, `mem_ce_no`, `mem_oe_no` and `mem_we_no` are high, `page_ld_o`, `rd_valid_o` and `err_o` are low, and no page counts as loaded, so the first accepted request performs a page-load cycle.
- R2: An aligned request whose upper address bits `req_addr_i[ADDR_W-1:LO_W]` equal the page last loaded issues no page-load cycle.
- R3: An aligned request to any other page raises `page_ld_o` for exactly one cycle, with `page_o` equal to the new upper address bits and `mem_ce_no` high. This cycle comes before the first byte cycle, and afterwards the new page counts as loaded.
- R4: Byte k (k = 0..3) of a word is accessed at `mem_addr_o = req_addr_i[LO_W-1:0] + k`, all within the same page.
- R5: Byte order is little-endian. Byte k carries `wdata[8k+7:8k]` on writes and fills `rd_data_o[8k+7:8k]` on reads.
- R6: For each read byte, `mem_ce_no` and `mem_oe_no` stay low for RD_WAIT cycles, and `mem_data_i` is sampled at the end of the last of them.
- R7: For each written byte, the byte is driven (`mem_data_oe_o` high) one cycle before `mem_we_no` falls. `mem_we_no` then stays low for WR_PULSE cycles, and the byte is still driven in the cycle in which `mem_we_no` returns high.
- R8: `req_ready_o` is low from the cycle after acceptance until the fourth byte completes. That is 4*RD_WAIT cycles for a read and 4*(WR_PULSE+2) cycles for a write, plus one cycle when a page load is needed.
- R9: A read raises `rd_valid_o` for exactly one cycle, in the cycle `req_ready_o` returns high. A write never raises it.
- R10: An accepted request with `req_addr_i[1:0] != 0` raises `err_o` for one cycle in the next cycle. It issues no page load and no chip-enable, and it leaves the loaded page unchanged.
- R11: The controller never drives the data bus while `mem_oe_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ADDR_W | Host byte address (word aligned) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write word |
| rd_valid_o | output | 1 | One-cycle read-data strobe |
| rd_data_o | output | 32 | Assembled read word |
| err_o | output | 1 | One-cycle unaligned-request flag |
| page_ld_o | output | 1 | Page latch load strobe |
| page_o | output | ADDR_W-LO_W | Value for the page latch |
| mem_addr_o | output | LO_W | Low-order memory address pins |
| mem_data_o | output | 8 | Byte driven to memory |
| mem_data_i | input | 8 | Byte returned by memory |
| mem_data_oe_o | output | 1 | Data bus output enable |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |

## Verification
The assertions watch the strobe relations on every cycle. They check that the page-load strobe lasts one cycle with chip-enable off, that data is set up before and held after write-enable, that the bus is never driven during output-enable, and that read-valid and the error flag are single-cycle pulses. Only the bench's scenarios can show the rest. That covers whether a page load happens at all (first access, page hit, page change, page state surviving a rejected request), where each byte lands in memory and in what order, the exact busy length for each kind of access, and the use of the top of a page.

// File: rtl/paged_sram_pkg.sv
package paged_sram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLOAD,
    ST_RD,
    ST_WSET,
    ST_WSTB,
    ST_WHLD
  } eng_state_e;

  localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/psc_page_track.sv
module psc_page_track #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_page_i,
  input  logic [PAGE_W-1:0] cmp_page_i,
  output logic              hit_o
);
  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      page_q  <= load_page_i;
    end
  end

  assign hit_o = valid_q && (page_q == cmp_page_i);

  // R3
  page_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hit_o == (cmp_page_i == $past(load_page_i))));
endmodule

// File: rtl/psc_byte_engine.sv
module psc_byte_engine
  import paged_sram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LO_W     = 16,
  parameter int unsigned RD_WAIT  = 2,
  parameter int unsigned WR_PULSE = 1,
  localparam int unsigned PAGE_W  = ADDR_W - LO_W,
  localparam int unsigned MAX_CNT = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE,
  localparam int unsigned CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1,
  localparam int unsigned IDX_W   = $clog2(BYTES_PER_WORD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [31:0]       req_wdata_i,
  input  logic              page_hit_i,
  output logic              page_ld_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic              err_o,
  output logic [LO_W-1:0]   mem_addr_o,
  output logic [7:0]        mem_data_o,
  input  logic [7:0]        mem_data_i,
  output logic              mem_data_oe_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no
);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_PULSE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES_PER_WORD - 1);

  eng_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LO_W-1:0]   lo_q;
  logic [PAGE_W-1:0] pend_page_q;
  logic              we_q;
  logic [31:0]       wdata_q;
  logic [31:0]       rdata_q;
  logic              rd_valid_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      cnt_q       <= '0;
      lo_q        <= '0;
      pend_page_q <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rd_valid_q  <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (req_addr_i[1:0] != 2'b00) begin
              err_q <= 1'b1;
            end else begin
              lo_q        <= req_addr_i[LO_W-1:0];
              pend_page_q <= req_addr_i[ADDR_W-1:LO_W];
              we_q        <= req_we_i;
              wdata_q     <= req_wdata_i;
              idx_q       <= '0;
              cnt_q       <= '0;
              if (!page_hit_i)   state_q <= ST_PLOAD;
              else if (req_we_i) state_q <= ST_WSET;
              else               state_q <= ST_RD;
            end
          end
        end
        ST_PLOAD: state_q <= we_q ? ST_WSET : ST_RD;
        ST_RD: begin
          if (cnt_q == RD_LAST) begin
            cnt_q <= '0;
            rdata_q[{idx_q, 3'b000} +: 8] <= mem_data_i;
            if (idx_q == IDX_LAST) begin
              state_q    <= ST_IDLE;
              rd_valid_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WSET: begin
          cnt_q   <= '0;
          state_q <= ST_WSTB;
        end
        ST_WSTB: begin
          if (cnt_q == WR_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_WHLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WHLD: begin
          if (idx_q == IDX_LAST) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_WSET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic wr_phase;
  assign wr_phase = (state_q == ST_WSET) || (state_q == ST_WSTB) || (state_q == ST_WHLD);

  assign req_ready_o   = (state_q == ST_IDLE);
  assign page_ld_o     = (state_q == ST_PLOAD);
  assign page_o        = pend_page_q;
  assign rd_valid_o    = rd_valid_q;
  assign rd_data_o     = rdata_q;
  assign err_o         = err_q;
  assign mem_addr_o    = {lo_q[LO_W-1:IDX_W], idx_q};
  assign mem_data_o    = wdata_q[{idx_q, 3'b000} +: 8];
  assign mem_data_oe_o = wr_phase;
  assign mem_ce_no     = !(wr_phase || (state_q == ST_RD));
  assign mem_oe_no     = (state_q != ST_RD);
  assign mem_we_no     = (state_q != ST_WSTB);

  // R3
  pld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ld_o |=> !page_ld_o);
  // R3
  pld_no_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ld_o |-> mem_ce_no);
  // R7
  we_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_data_oe_o);
  // R7
  we_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(mem_data_oe_o));
  // R7
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_data_oe_o);
  // R11
  no_contend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_data_oe_o);
  // R9
  rdv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R9
  rdv_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> req_ready_o);
  // R10
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mem_ce_no && !page_ld_o && req_ready_o));
  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_addr_i[1:0] == 2'b00) |=> !req_ready_o);
endmodule

// File: rtl/paged_sram_ctrl.sv
module paged_sram_ctrl #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LO_W     = 16,
  parameter int unsigned RD_WAIT  = 2,
  parameter int unsigned WR_PULSE = 1,
  localparam int unsigned PAGE_W  = ADDR_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic              err_o,
  output logic              page_ld_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [LO_W-1:0]   mem_addr_o,
  output logic [7:0]        mem_data_o,
  input  logic [7:0]        mem_data_i,
  output logic              mem_data_oe_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no
);
  logic page_hit;

  psc_page_track #(.PAGE_W(PAGE_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (page_ld_o),
    .load_page_i (page_o),
    .cmp_page_i  (req_addr_i[ADDR_W-1:LO_W]),
    .hit_o       (page_hit)
  );

  psc_byte_engine #(
    .ADDR_W   (ADDR_W),
    .LO_W     (LO_W),
    .RD_WAIT  (RD_WAIT),
    .WR_PULSE (WR_PULSE)
  ) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_addr_i    (req_addr_i),
    .req_we_i      (req_we_i),
    .req_wdata_i   (req_wdata_i),
    .page_hit_i    (page_hit),
    .page_ld_o     (page_ld_o),
    .page_o        (page_o),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .err_o         (err_o),
    .mem_addr_o    (mem_addr_o),
    .mem_data_o    (mem_data_o),
    .mem_data_i    (mem_data_i),
    .mem_data_oe_o (mem_data_oe_o),
    .mem_ce_no     (mem_ce_no),
    .mem_oe_no     (mem_oe_no),
    .mem_we_no     (mem_we_no)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_ready_o && mem_ce_no));
endmodule

// File: tb/tb_paged_sram_ctrl.sv
`timescale 1ns/1ps
module tb_paged_sram_ctrl;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned LO_W = 16;
  localparam int unsigned RD_WAIT = 2;
  localparam int unsigned WR_PULSE = 1;
  localparam int unsigned PAGE_W = ADDR_W - LO_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, err, page_ld, data_oe, ce_n, oe_n, we_n;
  logic [31:0] rd_data;
  logic [PAGE_W-1:0] page_out;
  logic [LO_W-1:0] mem_addr;
  logic [7:0] mem_wr, mem_rd;

  always #2.5 clk = ~clk;

  paged_sram_ctrl #(.ADDR_W(ADDR_W), .LO_W(LO_W), .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .err_o(err),
    .page_ld_o(page_ld), .page_o(page_out), .mem_addr_o(mem_addr),
    .mem_data_o(mem_wr), .mem_data_i(mem_rd), .mem_data_oe_o(data_oe),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n));

  // memory model with external page latch
  logic [7:0] mem [int unsigned];
  logic [PAGE_W-1:0] ext_page = '0;
  always @(posedge clk) begin
    if (page_ld) ext_page <= page_out;
    if (!ce_n && !we_n) mem[{8'h00, ext_page, mem_addr}] = mem_wr;
  end
  assign mem_rd = (!ce_n && !oe_n) ? mem[{8'h00, ext_page, mem_addr}] : 8'h00;

  int total = 0, bad = 0;
  int n_ld, n_rv, n_err, n_ce, n_we, tbad, rd_oe_cyc;
  logic [31:0] rv_data;
  logic [PAGE_W-1:0] ld_page;
  logic prev_we_n = 1'b1, prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (page_ld) begin
        n_ld++;
        ld_page = page_out;
        if (n_ce != 0) tbad++;
        if (!ce_n) tbad++;
      end
      if (rd_valid) begin n_rv++; rv_data = rd_data; end
      if (err) n_err++;
      if (!ce_n) n_ce++;
      if (!we_n) n_we++;
      if (!oe_n) rd_oe_cyc++;
      if (!we_n && !data_oe) tbad++;
      if (prev_we_n && !we_n && !prev_oe) tbad++;
      if (!prev_we_n && we_n && !data_oe) tbad++;
      if (!oe_n && data_oe) tbad++;
      prev_we_n = we_n;
      prev_oe = data_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input logic we, input logic [31:0] wd,
                       output int busy);
    n_ld = 0; n_rv = 0; n_err = 0; n_ce = 0; n_we = 0; tbad = 0; rd_oe_cyc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready && busy < 1000) begin
      busy++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk({ce_n, oe_n, we_n} == 3'b111, "R1 strobes", {ce_n, oe_n, we_n}, 3'b111);
    chk({page_ld, rd_valid, err} == 3'b000, "R1 pulses", {page_ld, rd_valid, err}, 0);
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input int exp_ld);
    int busy;
    issue(a, 1'b1, d, busy);
    chk(n_ld == exp_ld, "R2/R3 write page loads", n_ld, exp_ld);
    if (exp_ld == 1) chk(ld_page == a[ADDR_W-1:LO_W], "R3 page value", ld_page, a[ADDR_W-1:LO_W]);
    chk(busy == 4*(WR_PULSE+2) + exp_ld, "R8 write busy", busy, 4*(WR_PULSE+2) + exp_ld);
    chk(n_we == 4*WR_PULSE, "R7 we cycles", n_we, 4*WR_PULSE);
    chk(tbad == 0, "R7/R11 strobe timing", tbad, 0);
    chk(n_rv == 0, "R9 no rd_valid on write", n_rv, 0);
    for (int k = 0; k < 4; k++)
      chk(mem[32'(a) + k] == d[8*k +: 8], "R4/R5 byte placement", mem[32'(a) + k], d[8*k +: 8]);
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input int exp_ld);
    int busy;
    issue(a, 1'b0, 32'h0, busy);
    chk(n_ld == exp_ld, "R2/R3 read page loads", n_ld, exp_ld);
    chk(busy == 4*RD_WAIT + exp_ld, "R8 read busy", busy, 4*RD_WAIT + exp_ld);
    chk(rd_oe_cyc == 4*RD_WAIT, "R6 oe cycles", rd_oe_cyc, 4*RD_WAIT);
    chk(n_rv == 1, "R9 single rd_valid", n_rv, 1);
    chk(rv_data == exp, "R5/R6 read word", rv_data, exp);
    chk(tbad == 0, "R11 bus quiet", tbad, 0);
  endtask

  task automatic t_unaligned(input logic [ADDR_W-1:0] a);
    int busy;
    issue(a, 1'b1, 32'hDEAD_BEEF, busy);
    chk(n_err == 1, "R10 err pulse", n_err, 1);
    chk(n_ce == 0 && n_ld == 0, "R10 no memory cycle", n_ce + n_ld, 0);
    chk(busy == 0, "R10 stays ready", busy, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();                                   // R1
    t_write(24'h12_0040, 32'h4433_2211, 1);      // R1 first access loads page
    t_read (24'h12_0040, 32'h4433_2211, 0);      // R2 hit
    t_write(24'h12_FFFC, 32'hA5B6_C7D8, 0);      // R4 top of page
    t_read (24'h12_FFFC, 32'hA5B6_C7D8, 0);
    t_write(24'h34_0100, 32'h0F1E_2D3C, 1);      // R3 miss
    t_read (24'h12_0040, 32'h4433_2211, 1);      // R3 back
    t_unaligned(24'h56_0002);                    // R10 other page
    t_read (24'h12_FFFC, 32'hA5B6_C7D8, 0);      // R10 page kept
    t_unaligned(24'h12_0041);
    t_read (24'h34_0100, 32'h0F1E_2D3C, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule